// File: doc/BRIEF.md
# Pushbuffer Command Stream Decoder

This block sits between a command word source and the method dispatch logic of a graphics front end. It accepts a stream of 32-bit command words and turns it into separate method calls. Each call carries a method index, a 32-bit argument, a subchannel and the count of calls still pending in the current run, including the call itself.

The block does not know in advance whether a word is a header or a data word; its own state decides. A header word selects the addressing pattern for the data words that follow it. The method index can step up on every word, stay fixed, or step up once and then hold. Alternatively, the header can carry its own 13-bit argument and produce one call at once.

A non-incrementing header with a zero count makes the next word a 24-bit length word instead of data. Both sides of the block are valid/ready streams. The input is held off while an issued call waits at the output, so no word is lost or repeated.

Top module: `pb_cmd_decoder`

## Requirements
- R1: After reset, out_valid and mode_err are 0, in_ready is 1, and the first accepted word is treated as a header.
- R2: A header holds the method in bits 12:0, the subchannel in bits 15:13, a count or inline value in bits 28:16 and the mode in bits 31:29. Mode 1 loads method, subchannel and count; each following data word then produces a call with that word as argument, and the method rises by one after every call.
- R3: Mode 3 with a non-zero count loads the same fields. Every data word of the run uses the same method.
- R4: Mode 5 loads the fields. The first data word uses the loaded method, and every later word of the run uses the loaded method plus one.
- R5: Mode 4 produces exactly one call at once, using the header's method and subchannel, with bits 28:16 zero-extended as the argument and an emitted count of 0. The next word is again a header.
- R6: Mode 3 with a count of 0 makes the next word a length word. That word produces no call; its bits 23:0 become the run count, bits 31:24 are ignored, and the method stays fixed for the run.
- R7: The count on each call is the remaining count before it is decremented, so a run of N calls carries N, N-1, ... down to 1.
- R8: A header of mode 0, 2, 6 or 7 produces no call and sets mode_err, which stays 1 until reset; later commands decode normally.
- R9: While out_valid is 1 and out_ready is 0, the output fields hold steady and in_ready is 0. Under any pattern of output stalls, each call appears exactly once and in order.
- R10: Mode 1 or mode 5 with a count of 0 produces no call, and the next word is again a header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Command word present |
| in_ready | output | 1 | Decoder accepts a word this cycle |
| in_word | input | 32 | Command word |
| out_valid | output | 1 | Method call present |
| out_ready | input | 1 | Consumer takes the call this cycle |
| out_method | output | 13 | Method index of the call |
| out_subch | output | 3 | Subchannel of the call |
| out_arg | output | 32 | Argument of the call |
| out_count | output | 24 | Remaining count including this call |
| mode_err | output | 1 | Sticky flag for an unsupported header mode |

## Verification
On every cycle, the assertions check the following:
- a stalled call holds steady and blocks the input;
- the error flag never clears;
- each data word lowers the remaining count by exactly one;
- a length word never produces a call.

How headers are decoded can only be shown by the bench's scenarios. These include the method sequences of the three run modes and the inline argument extraction. They also cover the zero-count and length-word paths and the recovery after a bad mode. All of these depend on what the stream contained earlier.

// File: rtl/pb_cmd_decoder.sv
module pb_cmd_decoder #(
  parameter int WORD_W = 32,
  parameter int METH_W = 13,
  parameter int SUB_W  = 3,
  parameter int CNT_W  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_word,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [METH_W-1:0] out_method,
  output logic [SUB_W-1:0]  out_subch,
  output logic [WORD_W-1:0] out_arg,
  output logic [CNT_W-1:0]  out_count,
  output logic              mode_err
);
  localparam int HCNT_W = 13;
  localparam int HCNT_LO = METH_W + SUB_W;

  logic [CNT_W-1:0]  cnt;
  logic [METH_W-1:0] meth;
  logic [SUB_W-1:0]  sub;
  logic              fixed, once, pend;

  wire fire = in_valid && in_ready;
  wire [METH_W-1:0] h_meth = in_word[METH_W-1:0];
  wire [SUB_W-1:0]  h_sub  = in_word[HCNT_LO-1:METH_W];
  wire [HCNT_W-1:0] h_cnt  = in_word[HCNT_LO+HCNT_W-1:HCNT_LO];
  wire [2:0]        h_mode = in_word[WORD_W-1:WORD_W-3];
  wire [CNT_W-1:0]  h_cnt_x = {{(CNT_W-HCNT_W){1'b0}}, h_cnt};

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0; meth <= '0; sub <= '0;
      fixed <= 1'b0; once <= 1'b0; pend <= 1'b0; mode_err <= 1'b0;
      out_valid <= 1'b0; out_method <= '0; out_subch <= '0;
      out_arg <= '0; out_count <= '0;
    end else begin
      if (out_ready) out_valid <= 1'b0;
      if (fire) begin
        if (pend) begin
          pend <= 1'b0;
          cnt  <= in_word[CNT_W-1:0];
        end else if (cnt != '0) begin
          out_valid  <= 1'b1;
          out_method <= meth;
          out_subch  <= sub;
          out_arg    <= in_word;
          out_count  <= cnt;
          cnt <= cnt - 1'b1;
          if (!fixed) meth <= meth + 1'b1;
          if (once) fixed <= 1'b1;
        end else begin
          case (h_mode)
            3'd1, 3'd3, 3'd5: begin
              meth  <= h_meth;
              sub   <= h_sub;
              cnt   <= h_cnt_x;
              fixed <= (h_mode == 3'd3);
              once  <= (h_mode == 3'd5);
              pend  <= (h_mode == 3'd3) && (h_cnt == '0);
            end
            3'd4: begin
              meth  <= h_meth;
              sub   <= h_sub;
              fixed <= 1'b1;
              once  <= 1'b0;
              out_valid  <= 1'b1;
              out_method <= h_meth;
              out_subch  <= h_sub;
              out_arg    <= {{(WORD_W-HCNT_W){1'b0}}, h_cnt};
              out_count  <= cnt;
            end
            default: mode_err <= 1'b1;
          endcase
        end
      end
    end
  end

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_method) && $stable(out_subch)
                                   && $stable(out_arg) && $stable(out_count)));
  p_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);
  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mode_err |=> mode_err);
  p_cnt_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !pend && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
  p_len_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && pend) |=> !out_valid);
endmodule

// File: tb/pb_cmd_decoder_tb_top.sv
module pb_cmd_decoder_tb_top;
  logic clk = 0, rst_n = 0;
  logic in_valid = 0, out_ready = 1, stall = 0;
  logic [31:0] in_word = '0;
  logic in_ready, out_valid, mode_err;
  logic [12:0] out_method;
  logic [2:0] out_subch;
  logic [31:0] out_arg;
  logic [23:0] out_count;
  int n_chk = 0, n_bad = 0, n_got = 0, cyc = 0;
  logic [12:0] g_m [0:63];
  logic [2:0]  g_s [0:63];
  logic [31:0] g_a [0:63];
  logic [23:0] g_c [0:63];

  pb_cmd_decoder dut_i (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .out_valid(out_valid), .out_ready(out_ready), .out_method(out_method),
    .out_subch(out_subch), .out_arg(out_arg), .out_count(out_count), .mode_err(mode_err));

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    #2 out_ready = !stall || (cyc % 3 == 0);
  end

  always @(negedge clk)
    if (out_valid && out_ready && n_got < 64) begin
      g_m[n_got] = out_method; g_s[n_got] = out_subch;
      g_a[n_got] = out_arg; g_c[n_got] = out_count;
      n_got = n_got + 1;
    end

  function automatic logic [31:0] hdr(input int mode, input int cnt, input int sub, input int meth);
    return {mode[2:0], cnt[12:0], sub[2:0], meth[12:0]};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [31:0] w);
    @(negedge clk);
    in_valid = 1; in_word = w;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    #1 in_valid = 0;
  endtask

  task automatic drain();
    repeat (8) @(negedge clk);
  endtask

  task automatic start();
    drain();
    n_got = 0;
  endtask

  task automatic call(input string tag, input int i, input int m, input int s, input int a, input int c);
    chk({tag, " method"}, 32'(g_m[i]), m[31:0]);
    chk({tag, " subch"}, 32'(g_s[i]), s[31:0]);
    chk({tag, " arg"}, g_a[i], a[31:0]);
    chk({tag, " count"}, 32'(g_c[i]), c[31:0]);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 out_valid", 32'(out_valid), 0);
    chk("R1 mode_err", 32'(mode_err), 0);
    chk("R1 in_ready", 32'(in_ready), 1);
  endtask

  task automatic t_incr();
    start();
    send(hdr(1, 3, 2, 'h10)); send('hA1); send('hB2); send('hC3);
    drain();
    chk("R2 calls", n_got, 3);
    call("R2 c0", 0, 'h10, 2, 'hA1, 3);
    call("R2 c1", 1, 'h11, 2, 'hB2, 2);
    call("R7 c2", 2, 'h12, 2, 'hC3, 1);
  endtask

  task automatic t_fixed();
    start();
    send(hdr(3, 2, 5, 'h40)); send('h1111); send('h2222);
    drain();
    chk("R3 calls", n_got, 2);
    call("R3 c0", 0, 'h40, 5, 'h1111, 2);
    call("R3 c1", 1, 'h40, 5, 'h2222, 1);
  endtask

  task automatic t_once();
    start();
    send(hdr(5, 3, 1, 'h80)); send(7); send(8); send(9);
    drain();
    chk("R4 calls", n_got, 3);
    call("R4 c0", 0, 'h80, 1, 7, 3);
    call("R4 c1", 1, 'h81, 1, 8, 2);
    call("R4 c2", 2, 'h81, 1, 9, 1);
  endtask

  task automatic t_inline();
    start();
    send(hdr(4, 'h1ABC, 6, 'h123));
    drain();
    chk("R5 calls", n_got, 1);
    call("R5 inl", 0, 'h123, 6, 'h1ABC, 0);
    send(hdr(1, 1, 0, 'h7)); send('h55);
    drain();
    chk("R5 next header", n_got, 2);
    call("R5 after", 1, 'h7, 0, 'h55, 1);
  endtask

  task automatic t_pending();
    start();
    send(hdr(3, 0, 3, 'h20)); send('hFF000002);
    drain();
    chk("R6 length silent", n_got, 0);
    send('hD0); send('hD1);
    drain();
    chk("R6 calls", n_got, 2);
    call("R6 c0", 0, 'h20, 3, 'hD0, 2);
    call("R6 c1", 1, 'h20, 3, 'hD1, 1);
  endtask

  task automatic t_zero();
    start();
    send(hdr(1, 0, 1, 'h30)); send(hdr(5, 0, 1, 'h31));
    drain();
    chk("R10 no call", n_got, 0);
    send(hdr(1, 1, 4, 'h32)); send('hEE);
    drain();
    chk("R10 next header", n_got, 1);
    call("R10 after", 0, 'h32, 4, 'hEE, 1);
  endtask

  task automatic t_badmode();
    start();
    send(hdr(6, 2, 1, 'h50));
    drain();
    chk("R8 no call", n_got, 0);
    chk("R8 err set", 32'(mode_err), 1);
    send(hdr(0, 1, 1, 'h51)); send(hdr(1, 1, 1, 'h52)); send('h77);
    drain();
    chk("R8 recover", n_got, 1);
    call("R8 after", 0, 'h52, 1, 'h77, 1);
    chk("R8 sticky", 32'(mode_err), 1);
  endtask

  task automatic t_stall();
    start();
    stall = 1;
    send(hdr(1, 5, 7, 'h100));
    for (int i = 0; i < 5; i++) send(32'h900 + i);
    send(hdr(4, 'h33, 2, 'h9));
    drain(); drain();
    stall = 0;
    drain();
    chk("R9 calls", n_got, 6);
    for (int i = 0; i < 5; i++) call("R9 run", i, 'h100 + i, 7, 'h900 + i, 5 - i);
    call("R9 inl", 5, 'h9, 2, 'h33, 0);
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_incr();
    t_fixed();
    t_once();
    t_inline();
    t_pending();
    t_zero();
    t_stall();
    t_badmode();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule